// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block brings a serial transceiver channel out of reset in a fixed order when the receiver's clock-data-recovery loop is steered by hand rather than left to lock on its own. It holds the channel PLL in reset for a minimum time. It then releases the transmit side once the PLL reports lock. Next it releases the receiver's analog front end, but only after the reconfiguration logic is idle. Last, it moves the recovery loop from the reference clock to the incoming data before the receive digital logic leaves reset.

The three status inputs (PLL locked, reconfiguration busy, receiver PLL locked) are asynchronous to the system clock and each passes through a two-flop synchroniser. Every timed wait is a parameter counted in system clock cycles. If either lock indication is lost, the sequencer falls back to the step that waited for it. It then reasserts every control that follows that step and walks forward again. A single asynchronous active-low reset returns all outputs at once to the held-in-reset pattern.

Top module: `xcvr_rst_seq`

## Requirements
- R1: After `arst_n` is released, `pll_rst_o` stays high and falls on exactly the `PLL_RST_CYC`-th rising clock edge.
- R2: While `arst_n` is low, and for as long as `pll_rst_o` is high, the outputs are: `tx_dig_rst_o`, `rx_ana_rst_o`, `rx_dig_rst_o` and `lock_ref_o` high, with `lock_data_o` and `done_o` low.
- R3: Each status input reaches the state machine through two flops, so an output reacting to a status change moves on the third rising edge after that change.
- R4: `tx_dig_rst_o` stays high after the PLL reset ends until `pll_locked_i` is seen high, and then falls on the third edge after `pll_locked_i` rises.
- R5: `rx_ana_rst_o` falls `BUSY_GAP_CYC` edges after the synchronised busy signal is first seen low with the transmit side released. This is edge 3+`BUSY_GAP_CYC` after `busy_i` falls, or edge 1+`BUSY_GAP_CYC` after `tx_dig_rst_o` falls if busy was already low.
- R6: While `busy_i` stays high, `rx_ana_rst_o` stays high for any length of time.
- R7: Once `rx_ana_rst_o` is low, a rise of `rx_pll_locked_i` makes `lock_ref_o` fall and `lock_data_o` rise together on edge 3+`REF_HOLD_CYC` after the rise.
- R8: `DATA_HOLD_CYC` edges after `lock_data_o` rises, `rx_dig_rst_o` falls and `done_o` rises on the same edge.
- R9: Exactly one of `lock_ref_o` and `lock_data_o` is high at all times.
- R10: If `pll_locked_i` falls after the PLL reset has ended, on the third edge `tx_dig_rst_o`, `rx_ana_rst_o`, `rx_dig_rst_o` and `lock_ref_o` go high, `lock_data_o` and `done_o` go low, and `pll_rst_o` stays low. The sequence then resumes from the wait for PLL lock.
- R11: If `rx_pll_locked_i` falls while the loop is held on the reference clock, on data, or done, and the PLL stays locked, then on the third edge `rx_dig_rst_o` and `lock_ref_o` go high and `lock_data_o` and `done_o` go low. `tx_dig_rst_o` and `rx_ana_rst_o` stay low, and the sequence resumes from the wait for receiver lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| pll_locked_i | input | 1 | Channel PLL lock status, asynchronous |
| busy_i | input | 1 | Reconfiguration busy status, asynchronous |
| rx_pll_locked_i | input | 1 | Receiver PLL lock status, asynchronous |
| pll_rst_o | output | 1 | Channel PLL reset, active high |
| tx_dig_rst_o | output | 1 | Transmit digital reset, active high |
| rx_ana_rst_o | output | 1 | Receive analog reset, active high |
| rx_dig_rst_o | output | 1 | Receive digital reset, active high |
| lock_ref_o | output | 1 | Steer recovery loop to the reference clock |
| lock_data_o | output | 1 | Steer recovery loop to the received data |
| done_o | output | 1 | Sequence complete |

## Verification
A status change costs two synchroniser flops plus the state register, so an output that reacts to it moves on the third rising edge. Timed steps add their parameter count to that: 3+`BUSY_GAP_CYC` from a busy fall to the analog release, 3+`REF_HOLD_CYC` from receiver lock to the steering swap, and a further `DATA_HOLD_CYC` to done. The bench drives inputs and samples the whole output vector on falling edges. It checks each output one edge before its due edge, expecting the old value, and again on the due edge, expecting the new value. It does this across a sweep of busy release delays and for both kinds of lock loss.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_PLL_RST,
        ST_WAIT_PLL,
        ST_WAIT_BUSY,
        ST_SETTLE,
        ST_WAIT_RXPLL,
        ST_REF_HOLD,
        ST_DATA_HOLD,
        ST_READY
    } seq_state_t;

    typedef struct packed {
        logic pll_rst;
        logic tx_dig_rst;
        logic rx_ana_rst;
        logic rx_dig_rst;
        logic lock_ref;
        logic lock_data;
        logic done;
    } ctrl_t;

    localparam ctrl_t CTRL_HELD = '{pll_rst: 1'b1, tx_dig_rst: 1'b1, rx_ana_rst: 1'b1,
                                    rx_dig_rst: 1'b1, lock_ref: 1'b1, lock_data: 1'b0,
                                    done: 1'b0};

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stable_q;

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_i[b];
                stable_q <= meta_q;
            end
        end

        assign sync_o[b] = stable_q;
    end

endmodule

// File: rtl/xrs_decode.sv
module xrs_decode
    import xrs_pkg::*;
(
    input  seq_state_t state_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = CTRL_HELD;
        unique case (state_i)
            ST_PLL_RST: ;
            ST_WAIT_PLL: begin
                ctrl_o.pll_rst = 1'b0;
            end
            ST_WAIT_BUSY, ST_SETTLE: begin
                ctrl_o.pll_rst    = 1'b0;
                ctrl_o.tx_dig_rst = 1'b0;
            end
            ST_WAIT_RXPLL, ST_REF_HOLD: begin
                ctrl_o.pll_rst    = 1'b0;
                ctrl_o.tx_dig_rst = 1'b0;
                ctrl_o.rx_ana_rst = 1'b0;
            end
            ST_DATA_HOLD: begin
                ctrl_o.pll_rst    = 1'b0;
                ctrl_o.tx_dig_rst = 1'b0;
                ctrl_o.rx_ana_rst = 1'b0;
                ctrl_o.lock_ref   = 1'b0;
                ctrl_o.lock_data  = 1'b1;
            end
            ST_READY: begin
                ctrl_o.pll_rst    = 1'b0;
                ctrl_o.tx_dig_rst = 1'b0;
                ctrl_o.rx_ana_rst = 1'b0;
                ctrl_o.rx_dig_rst = 1'b0;
                ctrl_o.lock_ref   = 1'b0;
                ctrl_o.lock_data  = 1'b1;
                ctrl_o.done       = 1'b1;
            end
            default: ctrl_o = CTRL_HELD;
        endcase
    end

endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int PLL_RST_CYC   = 250,
    parameter int BUSY_GAP_CYC  = 2,
    parameter int REF_HOLD_CYC  = 1000,
    parameter int DATA_HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pll_locked_i,
    input  logic busy_i,
    input  logic rx_pll_locked_i,
    output logic pll_rst_o,
    output logic tx_dig_rst_o,
    output logic rx_ana_rst_o,
    output logic rx_dig_rst_o,
    output logic lock_ref_o,
    output logic lock_data_o,
    output logic done_o
);

    localparam int MAX_A  = (PLL_RST_CYC > BUSY_GAP_CYC) ? PLL_RST_CYC : BUSY_GAP_CYC;
    localparam int MAX_B  = (REF_HOLD_CYC > DATA_HOLD_CYC) ? REF_HOLD_CYC : DATA_HOLD_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LD_PLL  = CNT_W'(PLL_RST_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(BUSY_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REF  = CNT_W'(REF_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_DATA = CNT_W'(DATA_HOLD_CYC - 1);

    typedef struct packed {
        seq_state_t       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    logic [2:0] status_s;
    logic       pll_s, busy_s, rx_s;
    fsm_t       fsm_d, fsm_q;
    ctrl_t      ctl_d, ctl_q;

    xrs_sync #(.WIDTH(3)) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .async_i ({rx_pll_locked_i, busy_i, pll_locked_i}),
        .sync_o  (status_s)
    );

    assign pll_s  = status_s[0];
    assign busy_s = status_s[1];
    assign rx_s   = status_s[2];

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_PLL_RST: begin
                if (fsm_q.cnt == '0) fsm_d.st  = ST_WAIT_PLL;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_WAIT_PLL: begin
                if (pll_s) fsm_d.st = ST_WAIT_BUSY;
            end
            ST_WAIT_BUSY: begin
                if (!busy_s) begin
                    fsm_d.st  = ST_SETTLE;
                    fsm_d.cnt = LD_GAP;
                end
            end
            ST_SETTLE: begin
                if (fsm_q.cnt == '0) fsm_d.st  = ST_WAIT_RXPLL;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_WAIT_RXPLL: begin
                if (rx_s) begin
                    fsm_d.st  = ST_REF_HOLD;
                    fsm_d.cnt = LD_REF;
                end
            end
            ST_REF_HOLD: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.st  = ST_DATA_HOLD;
                    fsm_d.cnt = LD_DATA;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            ST_DATA_HOLD: begin
                if (fsm_q.cnt == '0) fsm_d.st  = ST_READY;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_READY: ;
            default: fsm_d.st = ST_PLL_RST;
        endcase

        // receiver lock lost: fall back to waiting for it
        if (!rx_s && (fsm_q.st == ST_REF_HOLD || fsm_q.st == ST_DATA_HOLD ||
                      fsm_q.st == ST_READY)) begin
            fsm_d.st = ST_WAIT_RXPLL;
        end
        // PLL lock lost: fall back further, overriding the above
        if (!pll_s && fsm_q.st != ST_PLL_RST && fsm_q.st != ST_WAIT_PLL) begin
            fsm_d.st = ST_WAIT_PLL;
        end
    end

    xrs_decode u_decode (
        .state_i (fsm_d.st),
        .ctrl_o  (ctl_d)
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            fsm_q <= '{st: ST_PLL_RST, cnt: LD_PLL};
            ctl_q <= CTRL_HELD;
        end else begin
            fsm_q <= fsm_d;
            ctl_q <= ctl_d;
        end
    end

    assign pll_rst_o    = ctl_q.pll_rst;
    assign tx_dig_rst_o = ctl_q.tx_dig_rst;
    assign rx_ana_rst_o = ctl_q.rx_ana_rst;
    assign rx_dig_rst_o = ctl_q.rx_dig_rst;
    assign lock_ref_o   = ctl_q.lock_ref;
    assign lock_data_o  = ctl_q.lock_data;
    assign done_o       = ctl_q.done;

    // R2
    held_pattern_chk: assert property (@(posedge clk) disable iff (!arst_n)
        pll_rst_o |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o &&
                       lock_ref_o && !lock_data_o && !done_o));

    // R9
    steer_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot({lock_ref_o, lock_data_o}));

    // R4
    tx_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(tx_dig_rst_o) |-> $past(pll_s));

    // R5
    ana_order_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rx_ana_rst_o) |-> (!tx_dig_rst_o && !pll_rst_o));

    // R8
    done_pattern_chk: assert property (@(posedge clk) disable iff (!arst_n)
        done_o |-> (!rx_dig_rst_o && !rx_ana_rst_o && !tx_dig_rst_o && lock_data_o));

    // R10
    pll_loss_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!pll_rst_o && !pll_s) |=> (tx_dig_rst_o && !pll_rst_o && !done_o));

    // R11
    rx_loss_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (done_o && pll_s && !rx_s) |=> (!done_o && rx_dig_rst_o && !tx_dig_rst_o));

endmodule

// File: tb/xcvr_rst_seq_test.sv
module xcvr_rst_seq_test;

    localparam int PR  = 6;
    localparam int GAP = 2;
    localparam int REF = 4;
    localparam int DAT = 5;

    // vector order: pll_rst, tx, rx_ana, rx_dig, lock_ref, lock_data, done
    localparam logic [6:0] V_HELD  = 7'b1111100;
    localparam logic [6:0] V_WPLL  = 7'b0111100;
    localparam logic [6:0] V_TXUP  = 7'b0011100;
    localparam logic [6:0] V_RXANA = 7'b0001100;
    localparam logic [6:0] V_DATA  = 7'b0001010;
    localparam logic [6:0] V_READY = 7'b0000011;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic arst_n = 1'b0;
    logic pll_lk = 1'b0;
    logic busy   = 1'b0;
    logic rx_lk  = 1'b0;
    logic pll_rst, tx_rst, rx_ana, rx_dig, l_ref, l_dat, done;
    int   n_chk = 0;
    int   n_bad = 0;

    xcvr_rst_seq #(
        .PLL_RST_CYC   (PR),
        .BUSY_GAP_CYC  (GAP),
        .REF_HOLD_CYC  (REF),
        .DATA_HOLD_CYC (DAT)
    ) uut (
        .clk             (clk),
        .arst_n          (arst_n),
        .pll_locked_i    (pll_lk),
        .busy_i          (busy),
        .rx_pll_locked_i (rx_lk),
        .pll_rst_o       (pll_rst),
        .tx_dig_rst_o    (tx_rst),
        .rx_ana_rst_o    (rx_ana),
        .rx_dig_rst_o    (rx_dig),
        .lock_ref_o      (l_ref),
        .lock_data_o     (l_dat),
        .done_o          (done)
    );

    wire [6:0] outs = {pll_rst, tx_rst, rx_ana, rx_dig, l_ref, l_dat, done};

    task automatic chk(input string tag, input logic [6:0] exp);
        n_chk++;
        if (outs !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, outs, exp);
        end
    endtask

    task automatic nw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bring_up(input logic busy_hi, input int d);
        arst_n = 1'b0; pll_lk = 1'b0; rx_lk = 1'b0; busy = busy_hi;
        nw(2);
        chk("R2 during async reset", V_HELD);
        arst_n = 1'b1;
        nw(PR - 1);
        chk("R1 R2 pll reset still held", V_HELD);
        nw(1);
        chk("R1 pll reset released", V_WPLL);
        nw(3);
        chk("R4 tx held without lock", V_WPLL);
        pll_lk = 1'b1;
        nw(2);
        chk("R3 R4 two-flop delay", V_WPLL);
        nw(1);
        chk("R4 tx released", V_TXUP);
        if (!busy_hi) begin
            nw(GAP);
            chk("R5 settle gap, busy low", V_TXUP);
            nw(1);
            chk("R5 analog released, busy low", V_RXANA);
        end else begin
            nw(d);
            chk("R6 held while busy", V_TXUP);
            busy = 1'b0;
            nw(2 + GAP);
            chk("R5 settle gap after busy fall", V_TXUP);
            nw(1);
            chk("R5 analog released after busy", V_RXANA);
        end
        nw(2);
        chk("R7 waiting receiver lock", V_RXANA);
        rx_lk = 1'b1;
        nw(2 + REF);
        chk("R7 reference hold", V_RXANA);
        nw(1);
        chk("R7 R9 steering swap", V_DATA);
        nw(DAT - 1);
        chk("R8 data hold", V_DATA);
        nw(1);
        chk("R8 done", V_READY);
    endtask

    initial begin
        @(negedge clk);
        bring_up(1'b0, 0);
        for (int d = 0; d < 6; d++) bring_up(1'b1, d);

        // R11: receiver lock loss from done
        rx_lk = 1'b0;
        nw(2);
        chk("R11 before loss seen", V_READY);
        nw(1);
        chk("R11 receiver lock lost", V_RXANA);
        rx_lk = 1'b1;
        nw(2 + REF);
        chk("R11 R7 relock reference hold", V_RXANA);
        nw(1);
        chk("R11 R7 relock swap", V_DATA);
        nw(DAT);
        chk("R11 R8 relock done", V_READY);

        // R10: PLL lock loss from done
        pll_lk = 1'b0;
        nw(2);
        chk("R10 before loss seen", V_READY);
        nw(1);
        chk("R10 pll lock lost", V_WPLL);
        nw(4);
        chk("R10 pll reset not reasserted", V_WPLL);
        pll_lk = 1'b1;
        nw(3);
        chk("R10 R4 tx released again", V_TXUP);
        nw(GAP);
        chk("R10 R5 settle gap", V_TXUP);
        nw(1);
        chk("R10 R5 analog released", V_RXANA);
        nw(REF);
        chk("R10 R7 reference hold, lock already up", V_RXANA);
        nw(1);
        chk("R10 R7 swap", V_DATA);
        nw(DAT - 1);
        chk("R10 R8 data hold", V_DATA);
        nw(1);
        chk("R10 R8 done", V_READY);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R8): actual not finished expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule